// File: doc/BRIEF.md
# Serial Monochrome LCD Page Sequencer

This block drives a small monochrome LCD controller over a write-only serial link. The panel is 84 columns by 48 rows, and its memory is split into six pages, each eight rows tall. The link uses five lines: an active-low chip select, a command/data select, a serial clock, serial data, and an active-low panel reset. After the block leaves reset it runs a fixed start-up script on its own. The script holds the panel in reset for 18 ms and then sends a set of configuration commands. It then shows inverse video briefly before returning to the normal display. Timed pauses of 100 ms, 200 ms and 100 ms separate these steps.

After the start-up script, two kinds of request are served. A refresh request rewrites the whole screen, page 0 first and page 5 last. For each page the block sends a three-command header, then switches to data mode and sends one byte per column. It fetches each byte from the host over a simple read port: it drives a column and page address with a one-cycle strobe, and takes the returned byte on the next cycle. A contrast request sends a two-byte command that carries the stored contrast value shifted right by one. A request that arrives while the block is busy is held and served later. If both kinds are waiting, the contrast request is served first. A busy flag and a one-cycle done pulse report progress.

Top module: `lcd_page_sequencer`

## Requirements
- R1: While `rst_n` is low, the outputs read as follows: `lcd_rst_n` = 0, `lcd_cs_n` = 1, `lcd_dc` = 0, `busy` = 1, `rd_en` = 0 and `done` = 0.
- R2: After `rst_n` rises, `lcd_rst_n` stays low for exactly 18 ms worth of clock cycles (CLK_HZ/1000*18), with `lcd_cs_n` held high for the whole pulse.
- R3: After the reset pulse the chip select goes low and ten command bytes (`lcd_dc` = 0) are sent in this order: 21, 06, 13, C0, 20, 0C, 20, 0D, 20, 0C (hex).
- R4: The start-up script pauses for 100 ms after the sixth byte, 200 ms after the eighth byte, and 100 ms after the tenth byte. After the last pause, chip select goes high and `done` pulses.
- R5: Each byte is shifted most significant bit first in SPI mode 0. Data is sampled on the rising serial clock edge. The serial clock is low whenever no byte is in flight, and it is never high while chip select is high.
- R6: `lcd_dc` holds the same value across all eight clock edges of a byte.
- R7: A refresh sends, for pages 0 to 5 in order: command bytes 20, 80 and (40 OR page), then 84 data bytes (`lcd_dc` = 1) for columns 0 to 83. Chip select goes high at the end of each page.
- R8: Each data byte is fetched with a one-cycle `rd_en` carrying `rd_col` < 84 and `rd_page` < 6. The byte on `rd_data` in the following cycle is the one sent. A refresh issues exactly 504 reads.
- R9: A contrast update sends command bytes 21 and (80 OR value>>1), where the value is the one captured with the last `contrast_req`. Examples: 00→80, 01→80, FF→FF.
- R10: A request that arrives during start-up or during another transfer is held and served afterwards. When both kinds are pending, the contrast update is sent before the refresh.
- R11: `busy` is high from reset until start-up completes and during every transfer. `done` pulses once for one cycle as each operation ends, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_req | input | 1 | One-cycle request for a full-screen refresh |
| contrast_req | input | 1 | One-cycle request for a contrast update |
| contrast_val | input | 8 | Contrast value, captured when contrast_req is high |
| rd_en | output | 1 | Host byte read strobe |
| rd_col | output | 7 | Column of the requested byte |
| rd_page | output | 3 | Page of the requested byte |
| rd_data | input | 8 | Host byte, valid the cycle after rd_en |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_dc | output | 1 | Command (0) or data (1) select |
| lcd_sclk | output | 1 | Serial clock |
| lcd_mosi | output | 1 | Serial data |
| lcd_rst_n | output | 1 | Panel reset, active low |
| busy | output | 1 | Start-up or a transfer is in progress |
| done | output | 1 | One-cycle pulse when an operation ends |

## Verification
The serial lines are decoded into a log of (command/data, byte) pairs, and that log is compared with streams built by bench functions. The host port returns bytes that depend on page, column and a per-frame seed. A wrong page order, a wrong column order, or a byte taken one cycle early or late therefore shows up as a mismatch. Requests are issued in several patterns: during start-up, during a contrast transfer, both in the same idle cycle, and as a random mix. These separate correct pending and priority behaviour from serving requests in arrival order or dropping them. Directed contrast values 00, 01 and FF test the shift and the OR at both ends of the range.

// File: rtl/lcd_page_sequencer.sv
module lcd_page_sequencer #(
  parameter int CLK_HZ = 50_000_000,
  parameter int NCOL   = 84,
  parameter int NPAGE  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    refresh_req,
  input  logic                    contrast_req,
  input  logic [7:0]              contrast_val,
  output logic                    rd_en,
  output logic [$clog2(NCOL)-1:0] rd_col,
  output logic [2:0]              rd_page,
  input  logic [7:0]              rd_data,
  output logic                    lcd_cs_n,
  output logic                    lcd_dc,
  output logic                    lcd_sclk,
  output logic                    lcd_mosi,
  output logic                    lcd_rst_n,
  output logic                    busy,
  output logic                    done
);
  localparam int HALF    = CLK_HZ / 5_000_000 + 1;
  localparam int RST_CYC = CLK_HZ / 1000 * 18;
  localparam int W100    = CLK_HZ / 10;
  localparam int W200    = CLK_HZ / 5;
  localparam int WW      = $clog2(W200 + 1);
  localparam int PHW     = $clog2(HALF) + 1;
  localparam int CW      = $clog2(NCOL);

  typedef enum logic [2:0] {S_RST, S_NEXT, S_WAIT, S_FETCH, S_LOAD, S_TX, S_IDLE} st_t;
  localparam logic [1:0] OP_INIT = 2'd0, OP_CTR = 2'd1, OP_FRM = 2'd2;
  localparam logic [1:0] K_CMD = 2'd0, K_WAIT = 2'd1, K_DATA = 2'd2, K_END = 2'd3;

  st_t            st;
  logic [1:0]     op, kind;
  logic [3:0]     idx;
  logic [7:0]     ibyte, sh, ctr_val, ctr_cur;
  logic [WW-1:0]  wcnt, wlim;
  logic [PHW-1:0] ph;
  logic [2:0]     bitc, page;
  logic [CW-1:0]  col;
  logic           sclk, shifting, pend_ref, pend_ctr, byte_end;

  always_comb begin
    kind  = K_CMD;
    ibyte = 8'h00;
    unique case (op)
      OP_INIT: unique case (idx)
        4'd0:  ibyte = 8'h21;
        4'd1:  ibyte = 8'h06;
        4'd2:  ibyte = 8'h13;
        4'd3:  ibyte = 8'hC0;
        4'd4:  ibyte = 8'h20;
        4'd5:  ibyte = 8'h0C;
        4'd7:  ibyte = 8'h20;
        4'd8:  ibyte = 8'h0D;
        4'd10: ibyte = 8'h20;
        4'd11: ibyte = 8'h0C;
        4'd6, 4'd9, 4'd12: kind = K_WAIT;
        default: kind = K_END;
      endcase
      OP_CTR: unique case (idx)
        4'd0:    ibyte = 8'h21;
        4'd1:    ibyte = 8'h80 | {1'b0, ctr_cur[7:1]};
        default: kind = K_END;
      endcase
      default: unique case (idx)
        4'd0:    ibyte = 8'h20;
        4'd1:    ibyte = 8'h80;
        4'd2:    ibyte = 8'h40 | {5'b0, page};
        default: kind = K_DATA;
      endcase
    endcase
  end

  assign wlim      = (idx == 4'd9) ? WW'(W200 - 1) : WW'(W100 - 1);
  assign byte_end  = shifting && sclk && ph == PHW'(HALF - 1) && bitc == 3'd7;
  assign lcd_sclk  = sclk;
  assign lcd_mosi  = sh[7];
  assign busy      = st != S_IDLE;
  assign rd_en     = st == S_FETCH;
  assign rd_col    = col;
  assign rd_page   = page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RST; op <= OP_INIT; idx <= '0; wcnt <= '0; ph <= '0; bitc <= '0;
      sh <= '0; sclk <= 1'b0; shifting <= 1'b0; page <= '0; col <= '0;
      ctr_val <= '0; ctr_cur <= '0; pend_ref <= 1'b0; pend_ctr <= 1'b0;
      lcd_cs_n <= 1'b1; lcd_dc <= 1'b0; lcd_rst_n <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (shifting) begin
        if (ph == PHW'(HALF - 1)) begin
          ph <= '0;
          if (!sclk) sclk <= 1'b1;
          else begin
            sclk <= 1'b0;
            if (bitc == 3'd7) shifting <= 1'b0;
            else begin bitc <= bitc + 3'd1; sh <= {sh[6:0], 1'b0}; end
          end
        end else ph <= ph + PHW'(1);
      end

      unique case (st)
        S_RST:
          if (wcnt == WW'(RST_CYC)) begin
            wcnt <= '0; lcd_rst_n <= 1'b1; lcd_cs_n <= 1'b0; idx <= '0; st <= S_NEXT;
          end else wcnt <= wcnt + WW'(1);
        S_NEXT: begin
          lcd_cs_n <= 1'b0;
          unique case (kind)
            K_CMD: begin
              lcd_dc <= 1'b0; sh <= ibyte; bitc <= '0; ph <= '0;
              sclk <= 1'b0; shifting <= 1'b1; st <= S_TX;
            end
            K_WAIT: begin wcnt <= '0; st <= S_WAIT; end
            K_DATA: begin lcd_dc <= 1'b1; st <= S_FETCH; end
            default: begin lcd_cs_n <= 1'b1; lcd_dc <= 1'b0; done <= 1'b1; st <= S_IDLE; end
          endcase
        end
        S_WAIT:
          if (wcnt == wlim) begin idx <= idx + 4'd1; st <= S_NEXT; end
          else wcnt <= wcnt + WW'(1);
        S_FETCH: st <= S_LOAD;
        S_LOAD: begin
          sh <= rd_data; bitc <= '0; ph <= '0; sclk <= 1'b0; shifting <= 1'b1; st <= S_TX;
        end
        S_TX:
          if (byte_end) begin
            if (op == OP_FRM && idx == 4'd3) begin
              if (col == CW'(NCOL - 1)) begin
                col <= '0; lcd_cs_n <= 1'b1; lcd_dc <= 1'b0;
                if (page == 3'(NPAGE - 1)) begin done <= 1'b1; st <= S_IDLE; end
                else begin page <= page + 3'd1; idx <= '0; st <= S_NEXT; end
              end else begin col <= col + CW'(1); st <= S_FETCH; end
            end else begin idx <= idx + 4'd1; st <= S_NEXT; end
          end
        default:
          if (pend_ctr) begin
            pend_ctr <= 1'b0; op <= OP_CTR; ctr_cur <= ctr_val; idx <= '0; st <= S_NEXT;
          end else if (pend_ref) begin
            pend_ref <= 1'b0; op <= OP_FRM; page <= '0; col <= '0; idx <= '0; st <= S_NEXT;
          end
      endcase

      if (refresh_req) pend_ref <= 1'b1;
      if (contrast_req) begin pend_ctr <= 1'b1; ctr_val <= contrast_val; end
    end
  end
endmodule

module lcd_page_sequencer_chk #(
  parameter int NCOL  = 84,
  parameter int NPAGE = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    lcd_cs_n,
  input logic                    lcd_dc,
  input logic                    lcd_sclk,
  input logic                    lcd_rst_n,
  input logic                    rd_en,
  input logic [$clog2(NCOL)-1:0] rd_col,
  input logic [2:0]              rd_page,
  input logic                    busy,
  input logic                    done
);
  p_rst_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_rst_n |-> lcd_cs_n);
  p_sclk_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_sclk |-> !lcd_cs_n);
  p_dc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_sclk |-> $stable(lcd_dc));
  p_rd_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (32'(rd_col) < NCOL && 32'(rd_page) < NPAGE && lcd_dc && !lcd_cs_n));
  p_rd_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind lcd_page_sequencer lcd_page_sequencer_chk #(.NCOL(NCOL), .NPAGE(NPAGE)) chk_i (
  .clk(clk), .rst_n(rst_n), .lcd_cs_n(lcd_cs_n), .lcd_dc(lcd_dc), .lcd_sclk(lcd_sclk),
  .lcd_rst_n(lcd_rst_n), .rd_en(rd_en), .rd_col(rd_col), .rd_page(rd_page),
  .busy(busy), .done(done)
);

// File: tb/lcd_page_sequencer_tb.sv
module lcd_page_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ  = 100_000;
  localparam int NCOL    = 84;
  localparam int NPAGE   = 6;
  localparam int RST_CYC = CLK_HZ / 1000 * 18;
  localparam int W100    = CLK_HZ / 10;
  localparam int W200    = CLK_HZ / 5;
  localparam int SLACK   = 64;

  logic clk = 1'b0, rst_n = 1'b0, refresh_req = 1'b0, contrast_req = 1'b0;
  logic [7:0] contrast_val = '0, rd_data = '0;
  logic rd_en, lcd_cs_n, lcd_dc, lcd_sclk, lcd_mosi, lcd_rst_n, busy, done;
  logic [6:0] rd_col;
  logic [2:0] rd_page;

  lcd_page_sequencer #(.CLK_HZ(CLK_HZ), .NCOL(NCOL), .NPAGE(NPAGE)) dut_i (
    .clk(clk), .rst_n(rst_n), .refresh_req(refresh_req), .contrast_req(contrast_req),
    .contrast_val(contrast_val), .rd_en(rd_en), .rd_col(rd_col), .rd_page(rd_page),
    .rd_data(rd_data), .lcd_cs_n(lcd_cs_n), .lcd_dc(lcd_dc), .lcd_sclk(lcd_sclk),
    .lcd_mosi(lcd_mosi), .lcd_rst_n(lcd_rst_n), .busy(busy), .done(done));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, ndone = 0, nrd = 0, ncs = 0, rst_low = 0;
  int dc_err = 0, ln = 0, nb = 0, tb0 = 0, finished = 0;
  int done_t [0:63];
  int unsigned hseed = 32'h5A;
  logic [8:0] lg [0:4095];
  int lt [0:4095];
  logic [7:0] dsh;
  logic cur_dc;

  function automatic logic [7:0] hostf(input logic [2:0] p, input logic [6:0] c);
    logic [31:0] v;
    v = hseed + 32'(p) * 37 + 32'(c) * 11;
    return v[7:0] ^ {c[4:0], 3'b000};
  endfunction

  function automatic logic [7:0] exp_init(input int i);
    case (i)
      0: return 8'h21; 1: return 8'h06; 2: return 8'h13; 3: return 8'hC0; 4: return 8'h20;
      5: return 8'h0C; 6: return 8'h20; 7: return 8'h0D; 8: return 8'h20; default: return 8'h0C;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_en) rd_data <= hostf(rd_page, rd_col);
  end

  always @(negedge clk) begin
    if (rst_n && !lcd_rst_n) rst_low++;
    if (rst_n && done) begin done_t[ndone[5:0]] = cyc; ndone++; end
    if (rst_n && rd_en) nrd++;
  end

  always @(posedge lcd_sclk or posedge lcd_cs_n) begin
    if (lcd_cs_n) begin nb = 0; ncs++; end
    else begin
      if (nb == 0) begin cur_dc = lcd_dc; tb0 = cyc; end
      else if (lcd_dc != cur_dc) dc_err++;
      dsh = {dsh[6:0], lcd_mosi};
      nb++;
      if (nb == 8) begin
        if (ln < 4096) begin lg[ln] = {cur_dc, dsh}; lt[ln] = tb0; end
        ln++; nb = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_byte(input int i, input logic dcx, input logic [7:0] b, input string req);
    logic [8:0] a;
    a = (i < ln && i < 4096) ? lg[i] : 9'h1FF;
    chk(a == {dcx, b}, req, int'(a), int'({dcx, b}));
  endtask

  task automatic chk_ctr(input int base, input logic [7:0] v);
    chk_byte(base, 1'b0, 8'h21, "R9");
    chk_byte(base + 1, 1'b0, 8'h80 | {1'b0, v[7:1]}, "R9");
  endtask

  task automatic chk_frame(input int base);
    for (int p = 0; p < NPAGE; p++) begin
      int o;
      o = base + p * (NCOL + 3);
      chk_byte(o, 1'b0, 8'h20, "R7");
      chk_byte(o + 1, 1'b0, 8'h80, "R7");
      chk_byte(o + 2, 1'b0, 8'h40 | 8'(p), "R7");
      for (int c = 0; c < NCOL; c++)
        chk_byte(o + 3 + c, 1'b1, hostf(3'(p), 7'(c)), "R7/R8");
    end
  endtask

  task automatic wait_done(input int k);
    while (ndone < k) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(input bit r, input bit c, input logic [7:0] v);
    @(negedge clk);
    refresh_req = r; contrast_req = c; contrast_val = v;
    @(negedge clk);
    refresh_req = 1'b0; contrast_req = 1'b0;
  endtask

  task automatic finish_run();
    if (finished == 0) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    finish_run();
  end

  initial begin
    int base, crs, rds;
    logic [7:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(lcd_rst_n == 0 && lcd_cs_n == 1 && lcd_dc == 0, "R1 panel lines", int'({lcd_rst_n, lcd_cs_n, lcd_dc}), 3'b010);
    chk(busy == 1 && rd_en == 0 && done == 0, "R1 status", int'({busy, rd_en, done}), 3'b100);
    #1 rst_n = 1'b1;

    repeat (5000) @(negedge clk);
    crs = ncs; rds = nrd;
    pulse(1'b1, 1'b0, 8'h00);
    pulse(1'b0, 1'b1, 8'hA7);
    chk(busy == 1, "R11 busy during start-up", int'(busy), 1);
    wait_done(3);

    chk(rst_low == RST_CYC, "R2 reset pulse width", rst_low, RST_CYC);
    for (int i = 0; i < 10; i++) chk_byte(i, 1'b0, exp_init(i), "R3/R5");
    chk(lt[6] - lt[5] >= W100 && lt[6] - lt[5] <= W100 + SLACK, "R4 first pause", lt[6] - lt[5], W100);
    chk(lt[8] - lt[7] >= W200 && lt[8] - lt[7] <= W200 + SLACK, "R4 second pause", lt[8] - lt[7], W200);
    chk(done_t[0] - lt[9] >= W100 && done_t[0] - lt[9] <= W100 + SLACK, "R4 last pause", done_t[0] - lt[9], W100);
    chk_ctr(10, 8'hA7);
    chk_frame(12);
    chk(ln == 12 + NPAGE * (NCOL + 3), "R10 nothing extra", ln, 12 + NPAGE * (NCOL + 3));
    chk(nrd - rds == NCOL * NPAGE, "R8 read count", nrd - rds, NCOL * NPAGE);
    chk(busy == 0 && lcd_sclk == 0, "R11/R5 idle", int'({busy, lcd_sclk}), 0);

    base = ln;
    pulse(1'b0, 1'b1, 8'h00); wait_done(4); chk_ctr(base, 8'h00);
    chk_byte(base + 1, 1'b0, 8'h80, "R9 value 00");
    base = ln;
    pulse(1'b0, 1'b1, 8'h01); wait_done(5); chk_byte(base + 1, 1'b0, 8'h80, "R9 value 01");
    base = ln;
    pulse(1'b0, 1'b1, 8'hFF); wait_done(6); chk_byte(base + 1, 1'b0, 8'hFF, "R9 value FF");

    base = ln; hseed = 32'hC3;
    pulse(1'b0, 1'b1, 8'h3C);
    repeat (3) @(negedge clk);
    pulse(1'b1, 1'b0, 8'h00);
    wait_done(8);
    chk(ndone == 8, "R10/R11 one done per operation", ndone, 8);
    chk_ctr(base, 8'h3C);
    crs = ncs;
    chk_frame(base + 2);

    for (int it = 0; it < 5; it++) begin
      int r, k;
      r = int'($urandom % 3);
      v = 8'($urandom);
      base = ln; k = ndone;
      if (r != 0) hseed = $urandom;
      if (r == 0) begin pulse(1'b0, 1'b1, v); wait_done(k + 1); chk_ctr(base, v); end
      else if (r == 1) begin
        crs = ncs;
        pulse(1'b1, 1'b0, 8'h00); wait_done(k + 1); chk_frame(base);
        chk(ncs - crs == NPAGE, "R7 chip select per page", ncs - crs, NPAGE);
      end else begin
        pulse(1'b1, 1'b1, v); wait_done(k + 2);
        chk_ctr(base, v); chk_frame(base + 2);
      end
    end

    chk(dc_err == 0, "R6 dc stable within bytes", dc_err, 0);
    chk(busy == 0 && lcd_cs_n == 1, "R11 idle at end", int'({busy, lcd_cs_n}), 2'b01);
    finish_run();
  end
endmodule